// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Sequencer

This block stands in for the write-side command logic of a small parallel NOR flash whose array is held in on-chip storage. A host issues single-cycle bus writes and reads. Writes must follow the usual two-cycle unlock handshake before the array can be changed. After the handshake, one command byte chooses either a single byte program or a sector erase. An erase needs a second unlock handshake before its confirm byte.

Programming can only clear bits: the stored byte becomes the AND of its old value and the written byte. An erase sets every byte of the sector that holds the written address to 0xFF. Both operations complete in the cycle of the final write, so the block has no busy period.

Reads of one, two or four bytes return array bytes through a fixed lane swizzle. Any write that breaks the protocol raises a one-cycle error pulse and leaves the array as it was. The unlock addresses are decoded on the full bus address. The array is indexed by the low `ADDR_W` bits of that address, so the array repeats across the bus range.

Top module: `nor_flash_seq`

## Requirements
- R1: A synchronous reset returns the sequencer to waiting for the first unlock, clears `err` and `rdata`, and leaves the array contents unchanged.
- R2: In the first-unlock state, only a byte write of 0xAA to bus address 0x05555 advances the sequencer. Any other write gives `err`=1 in the following cycle only, returns to the first-unlock state, and leaves the array unchanged.
- R3: In the second-unlock state, a byte write of 0x55 to bus address 0x0AAAA or to 0x02AAA advances the sequencer. Any other write is an error, as in R2.
- R4: After the unlock pair, command byte 0xA0 enters program mode and command byte 0x80 enters the erase path. Any other byte is an error and returns to the first-unlock state.
- R5: In program mode, the next byte write to address A stores old AND new into array byte (A XOR 3), then returns to the first-unlock state without an error.
- R6: The erase path needs another 0xAA at 0x05555 and then 0x55 at 0x0AAAA or 0x02AAA. After that, byte 0x30 sets to 0xFF every byte of the sector holding the written address (the array index with its low `SECT_W` bits ignored), and leaves every other sector unchanged. Any other final byte is an error.
- R7: A write whose `size` is not 0 (0 means byte) is an error in every state. It returns the sequencer to the first-unlock state and leaves the array unchanged.
- R8: A read registers `rdata` one cycle after `rd_en`. The `size` encoding is 0 = byte, 1 = halfword, 2 or 3 = word.
  - A byte read returns array byte (A XOR 3) in bits 7:0.
  - A halfword read takes H = A with bit 0 cleared, then XOR 2, and returns {byte H, byte H+1} in bits 15:0.
  - A word read takes W = A with bits 1:0 cleared and returns {byte W, W+1, W+2, W+3}, with byte W in the most significant position.
  - Unused upper bits read as zero.
  - `rdata` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| addr | input | BUS_AW | Bus byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse after an illegal write |

## Verification
The bench goes after the paths that separate a real sequencer from a loose one:
- Both second-unlock addresses are accepted, in both the program and the erase paths.
- A first unlock to an aliased address (0x15555) is refused. A design that masked the address before decoding would accept it.
- Unknown command bytes and wrong erase confirm bytes are rejected.
- A halfword write sent while in program mode is refused. A faulty design would program the array there or stay armed.

A second program over an already-programmed byte shows whether the array stores the AND or simply overwrites. Erasing one sector and reading its neighbour shows whether the erase range is too wide. Lane reads at all three sizes catch a wrong XOR or a wrong byte order. A reset in the middle of a sequence, followed by a read, shows whether reset lost the array or left the sequencer armed.

// File: rtl/nor_flash_seq.sv
module nor_flash_seq #(
  parameter int BUS_AW = 17,
  parameter int ADDR_W = 12,
  parameter int SECT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        size,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [BUS_AW-1:0] UNLOCK_A  = BUS_AW'(32'h5555);
  localparam logic [BUS_AW-1:0] UNLOCK_B0 = BUS_AW'(32'hAAAA);
  localparam logic [BUS_AW-1:0] UNLOCK_B1 = BUS_AW'(32'h2AAA);

  typedef enum logic [2:0] {
    S_U1, S_U2, S_CMD, S_EU1, S_EU2, S_ECMD, S_PROG
  } st_t;

  st_t st, nst;
  logic [7:0] mem [DEPTH];
  logic bad, do_prog, do_erase;

  wire [ADDR_W-1:0] idx    = addr[ADDR_W-1:0];
  wire [ADDR_W-1:0] b_idx  = idx ^ ADDR_W'(3);
  wire [ADDR_W-1:0] h_idx  = {idx[ADDR_W-1:1], 1'b0} ^ ADDR_W'(2);
  wire [ADDR_W-1:0] w_idx  = {idx[ADDR_W-1:2], 2'b00};
  wire              byte_wr = wr_en && (size == 2'd0);
  wire              hit_u1  = (addr == UNLOCK_A) && (wdata == 8'hAA);
  wire              hit_u2  = (addr == UNLOCK_B0 || addr == UNLOCK_B1) && (wdata == 8'h55);

  always_comb begin
    nst = st;
    bad = 1'b0;
    do_prog = 1'b0;
    do_erase = 1'b0;
    if (wr_en) begin
      if (size != 2'd0) begin
        bad = 1'b1;
        nst = S_U1;
      end else begin
        case (st)
          S_U1, S_EU1: begin
            if (hit_u1) nst = (st == S_U1) ? S_U2 : S_EU2;
            else begin bad = 1'b1; nst = S_U1; end
          end
          S_U2, S_EU2: begin
            if (hit_u2) nst = (st == S_U2) ? S_CMD : S_ECMD;
            else begin bad = 1'b1; nst = S_U1; end
          end
          S_CMD: begin
            if (wdata == 8'hA0) nst = S_PROG;
            else if (wdata == 8'h80) nst = S_EU1;
            else begin bad = 1'b1; nst = S_U1; end
          end
          S_ECMD: begin
            if (wdata == 8'h30) do_erase = 1'b1;
            else bad = 1'b1;
            nst = S_U1;
          end
          S_PROG: begin
            do_prog = 1'b1;
            nst = S_U1;
          end
          default: nst = S_U1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_U1;
      err <= 1'b0;
    end else begin
      st  <= nst;
      err <= bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && do_prog) mem[b_idx] <= mem[b_idx] & wdata;
    if (!rst && do_erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((i >> SECT_W) == (int'(idx) >> SECT_W)) mem[i] <= 8'hFF;
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    case (size)
      2'd0:    rd_val = {24'h0, mem[b_idx]};
      2'd1:    rd_val = {16'h0, mem[h_idx], mem[h_idx | ADDR_W'(1)]};
      default: rd_val = {mem[w_idx], mem[w_idx | ADDR_W'(1)],
                         mem[w_idx | ADDR_W'(2)], mem[w_idx | ADDR_W'(3)]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(st));
  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> st == S_U1);
  // R2
  unlock_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_U1 && byte_wr && hit_u1) |=> (st == S_U2 && !err));
  // R4
  prog_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_CMD && byte_wr && wdata == 8'hA0) |=> st == S_PROG);
  // R5
  prog_and_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_PROG && byte_wr) |=>
      (mem[$past(b_idx)] == ($past(mem[b_idx]) & $past(wdata)) && st == S_U1 && !err));
  // R6
  erase_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_ECMD && byte_wr && wdata == 8'h30) |=> mem[$past(idx)] == 8'hFF);
  // R7
  wide_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && size != 2'd0) |=> (err && st == S_U1));
endmodule

// File: tb/nor_flash_seq_tb.sv
module nor_flash_seq_tb_top;
  localparam int AW = 12;
  localparam int SW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] size = 2'd0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  logic err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mm [DEPTH];
  int mst = 0;

  nor_flash_seq #(.BUS_AW(17), .ADDR_W(AW), .SECT_W(SW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .size(size),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit we, input bit re, input logic [1:0] sz,
                    input logic [16:0] a, input logic [7:0] d, input string tag);
    bit ee;
    logic [31:0] er;
    int ai, hb, wb;
    ee = 0; er = '0;
    wr_en = we; rd_en = re; size = sz; addr = a; wdata = d;
    ai = int'(a) & (DEPTH - 1);
    if (re) begin
      hb = (ai & ~1) ^ 2;
      wb = ai & ~3;
      if (sz == 2'd0) er = {24'h0, mm[ai ^ 3]};
      else if (sz == 2'd1) er = {16'h0, mm[hb], mm[hb + 1]};
      else er = {mm[wb], mm[wb + 1], mm[wb + 2], mm[wb + 3]};
    end
    if (we) begin
      if (sz != 2'd0) begin ee = 1; mst = 0; end
      else if (mst == 0 || mst == 3) begin
        if (a == 17'h05555 && d == 8'hAA) mst = mst + 1; else begin ee = 1; mst = 0; end
      end else if (mst == 1 || mst == 4) begin
        if ((a == 17'h0AAAA || a == 17'h02AAA) && d == 8'h55) mst = mst + 1;
        else begin ee = 1; mst = 0; end
      end else if (mst == 2) begin
        if (d == 8'hA0) mst = 6;
        else if (d == 8'h80) mst = 3;
        else begin ee = 1; mst = 0; end
      end else if (mst == 5) begin
        if (d == 8'h30) begin
          for (int j = 0; j < DEPTH; j++) if ((j >> SW) == (ai >> SW)) mm[j] = 8'hFF;
        end else ee = 1;
        mst = 0;
      end else begin
        mm[ai ^ 3] = mm[ai ^ 3] & d;
        mst = 0;
      end
    end
    @(posedge clk); #1;
    chk({tag, " err"}, {31'h0, err}, {31'h0, ee});
    if (re) chk({tag, " rdata"}, rdata, er);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input string tag);
    op(1, 0, 2'd0, a, d, tag);
  endtask
  task automatic rd(input logic [1:0] sz, input logic [16:0] a, input string tag);
    op(0, 1, sz, a, 8'h00, tag);
  endtask
  task automatic prog(input logic [16:0] a, input logic [7:0] d, input logic [16:0] u2, input string tag);
    wr(17'h05555, 8'hAA, tag); wr(u2, 8'h55, tag); wr(17'h05555, 8'hA0, tag); wr(a, d, tag);
  endtask
  task automatic erase(input logic [16:0] a, input logic [7:0] conf, input string tag);
    wr(17'h05555, 8'hAA, tag); wr(17'h0AAAA, 8'h55, tag); wr(17'h05555, 8'h80, tag);
    wr(17'h05555, 8'hAA, tag); wr(17'h02AAA, 8'h55, tag); wr(a, conf, tag);
  endtask
  task automatic do_reset;
    rst = 1; mst = 0;
    @(posedge clk); #1;
    chk("R1 reset err", {31'h0, err}, 32'h0);
    chk("R1 reset rdata", rdata, 32'h0);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < DEPTH; j++) mm[j] = 8'h00;
    @(negedge clk); @(negedge clk);
    do_reset();
    for (int s = 0; s < 4; s++) erase(17'(s << SW), 8'h30, "R6 full erase");
    rd(2'd2, 17'h00000, "R6 erased word");
    prog(17'h00100, 8'h5A, 17'h0AAAA, "R5 program");
    rd(2'd0, 17'h00100, "R5 readback");
    prog(17'h00100, 8'h0F, 17'h02AAA, "R3 alt unlock R5 and");
    rd(2'd0, 17'h00100, "R5 and readback");
    prog(17'h00101, 8'h12, 17'h0AAAA, "R5 lane1");
    prog(17'h00102, 8'h34, 17'h0AAAA, "R5 lane2");
    prog(17'h00103, 8'h56, 17'h0AAAA, "R5 lane3");
    rd(2'd0, 17'h00102, "R8 byte lane");
    rd(2'd1, 17'h00100, "R8 half low");
    rd(2'd1, 17'h00103, "R8 half high");
    rd(2'd2, 17'h00101, "R8 word");
    rd(2'd3, 17'h00100, "R8 word size3");
    wr(17'h05555, 8'hAB, "R2 bad data");
    wr(17'h05554, 8'hAA, "R2 bad addr");
    wr(17'h15555, 8'hAA, "R2 alias addr");
    wr(17'h05555, 8'hA0, "R2 cmd without unlock");
    wr(17'h00100, 8'h00, "R2 no effect");
    rd(2'd2, 17'h00100, "R2 array unchanged");
    wr(17'h05555, 8'hAA, "R3 u1"); wr(17'h01AAA, 8'h55, "R3 bad addr");
    wr(17'h05555, 8'hAA, "R3 u1"); wr(17'h0AAAA, 8'h54, "R3 bad data");
    wr(17'h05555, 8'hAA, "R4 u1"); wr(17'h0AAAA, 8'h55, "R4 u2"); wr(17'h05555, 8'h90, "R4 unknown cmd");
    wr(17'h00100, 8'h00, "R4 back to idle");
    op(1, 0, 2'd1, 17'h05555, 8'hAA, "R7 half write idle");
    wr(17'h05555, 8'hAA, "R7 u1"); wr(17'h0AAAA, 8'h55, "R7 u2"); wr(17'h05555, 8'hA0, "R7 cmd");
    op(1, 0, 2'd1, 17'h00100, 8'h00, "R7 half write in program");
    op(1, 0, 2'd2, 17'h00100, 8'h00, "R7 word write");
    rd(2'd2, 17'h00100, "R7 array unchanged");
    prog(17'h00500, 8'h11, 17'h0AAAA, "R5 sector1");
    erase(17'h004A0, 8'h20, "R6 bad confirm");
    rd(2'd0, 17'h00500, "R6 bad confirm no erase");
    erase(17'h004A0, 8'h30, "R6 sector1 erase");
    rd(2'd0, 17'h00500, "R6 sector1 erased");
    rd(2'd2, 17'h00100, "R6 sector0 kept");
    wr(17'h05555, 8'hAA, "R1 partial"); wr(17'h0AAAA, 8'h55, "R1 partial");
    do_reset();
    wr(17'h05555, 8'hA0, "R1 reset disarms");
    rd(2'd2, 17'h00100, "R1 array kept");
    rd(2'd0, 17'h00FFF, "R8 top byte");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule